// File: doc/BRIEF.md
# Trigger-Primitive Spy Capture Bank

The block records trigger-primitive samples from a set of parallel 10-bit channels (eight by default) into one small first-in first-out store per channel. A host reads them back later over a 16-bit register bus. While the `run_active` input is high, every clock writes one sample per channel. When `run_active` is low, nothing is written. A one-cycle `soft_clr` pulse discards everything stored in all channels.

Each channel has its own read address. A read of that address removes the oldest entry and returns it with the channel's empty flag just above the data. A separate status address returns the full and empty flags of every channel in one word. This lets the host see which stores hold data, or have overflowed, without popping anything. A single clock drives both the capture side and the bus side.

Top module: `tp_spy_capture`

## Requirements
- R1: While `run_active` is high and `soft_clr` is low, each clock appends the sample on each channel's lane (channel c occupies `sample_in[c*10 +: 10]`) to that channel's store. Reads return the stored samples in the order they were written.
- R2: While `run_active` is low, no sample is stored, and the flags seen at the status address do not change.
- R3: Each store holds 16 entries. A write into a full store is dropped, and the full flag stays set until an entry is removed.
- R4: Bus addresses 0x35 to 0x3C read channels 1 to 8 in ascending order. The returned word has the data in bits [9:0], the channel's empty flag in bit 10, and zero in bits [15:11].
- R5: A read of an empty channel returns 0x0400, which is the empty bit set and the data at zero. It removes nothing.
- R6: A read of a non-empty channel removes exactly one entry, the oldest.
- R7: Address 0x71 returns the full flags in bits [15:8] and the empty flags in bits [7:0]. Channel 1 sits in the lowest bit of each group. The read removes nothing.
- R8: A one-cycle `soft_clr` pulse empties every store in that cycle. It takes priority over a capture in the same cycle.
- R9: `rd_data` is registered. It takes the value for a strobed address one clock after `rd_strobe` and holds it until the next strobe. Addresses other than the channel and status addresses read as zero.
- R10: After reset every store is empty and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_active | input | 1 | Capture enable |
| soft_clr | input | 1 | One-cycle pulse that empties all stores |
| sample_in | input | 80 | Channel samples, channel c in bits [c*10 +: 10] |
| rd_strobe | input | 1 | Marks a bus read access in this cycle |
| rd_addr | input | 8 | Bus read address |
| rd_data | output | 16 | Registered read data |

## Verification
A table of six sample patterns is pushed into all channels before any read. The patterns are all zeros, all ones, the two alternating-bit words, and single-bit words at each end. Each channel's lane is additionally scrambled by a channel-dependent mask. Draining every channel therefore separates stuck or swapped data bits, lane-to-address mix-ups and ordering faults. A run of twenty back-to-back captures shows that the surplus is dropped and that the full flags pack into the upper status byte. Drains past the last entry, capture with the enable low, a clear that coincides with a capture, and strobes to unused addresses cover the remaining corner cases.

// File: rtl/spy_pkg.sv
package spy_pkg;
   localparam int unsigned SPY_NCH     = 8;
   localparam int unsigned SPY_DW      = 10;
   localparam int unsigned SPY_DEPTH   = 16;
   localparam int unsigned SPY_AW      = 8;
   localparam int unsigned SPY_BUS_W   = 16;
   localparam logic [7:0]  SPY_CH_BASE = 8'h35;
   localparam logic [7:0]  SPY_STAT    = 8'h71;
endpackage

// File: rtl/spy_fifo.sv
module spy_fifo #(
   parameter int unsigned DW    = 10,
   parameter int unsigned DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   output logic [DW-1:0] head,
   output logic          empty,
   output logic          full
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = AW + 1;

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("spy_fifo: DEPTH must be a power of two");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;
   logic          do_wr, do_rd;

   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));
   assign do_wr = wr_en && !full && !clr;
   assign do_rd = rd_en && !empty && !clr;
   assign head  = empty ? '0 : mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_wr) wr_ptr <= wr_ptr + AW'(1);
         if (do_rd) rd_ptr <= rd_ptr + AW'(1);
         count <= count + CW'(do_wr) - CW'(do_rd);
      end
   end

   always_ff @(posedge clk) begin
      if (do_wr) mem[wr_ptr] <= wr_data;
   end
endmodule

// File: rtl/spy_rd_mux.sv
module spy_rd_mux #(
   parameter int unsigned NCH     = 8,
   parameter int unsigned DW      = 10,
   parameter int unsigned AW      = 8,
   parameter int unsigned BUS_W   = 16,
   parameter logic [7:0]  CH_BASE = 8'h35,
   parameter logic [7:0]  STAT    = 8'h71
) (
   input  logic              rd_strobe,
   input  logic [AW-1:0]     rd_addr,
   input  logic [NCH*DW-1:0] heads,
   input  logic [NCH-1:0]    empty_v,
   input  logic [NCH-1:0]    full_v,
   output logic [NCH-1:0]    pop_v,
   output logic [BUS_W-1:0]  rd_next
);
   logic [NCH-1:0] hit;

   for (genvar c = 0; c < NCH; c++) begin : g_hit
      assign hit[c]   = rd_strobe && (rd_addr == AW'(CH_BASE + c));
      assign pop_v[c] = hit[c] && !empty_v[c];
   end

   always_comb begin
      rd_next = '0;
      for (int c = 0; c < NCH; c++) begin
         if (hit[c]) begin
            rd_next[DW-1:0] = heads[c*DW +: DW];
            rd_next[DW]     = empty_v[c];
         end
      end
      if (rd_strobe && rd_addr == AW'(STAT)) begin
         rd_next[2*NCH-1:0] = {full_v, empty_v};
      end
   end
endmodule

// File: rtl/tp_spy_capture.sv
module tp_spy_capture
   import spy_pkg::*;
#(
   parameter int unsigned NCH     = SPY_NCH,
   parameter int unsigned DW      = SPY_DW,
   parameter int unsigned DEPTH   = SPY_DEPTH,
   parameter int unsigned AW      = SPY_AW,
   parameter int unsigned BUS_W   = SPY_BUS_W,
   parameter logic [7:0]  CH_BASE = SPY_CH_BASE,
   parameter logic [7:0]  STAT    = SPY_STAT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_active,
   input  logic              soft_clr,
   input  logic [NCH*DW-1:0] sample_in,
   input  logic              rd_strobe,
   input  logic [AW-1:0]     rd_addr,
   output logic [BUS_W-1:0]  rd_data
);
   if (2 * NCH > BUS_W) begin : g_bad_stat
      $error("tp_spy_capture: status word cannot hold 2*NCH flags");
   end
   if (DW + 1 > BUS_W) begin : g_bad_dw
      $error("tp_spy_capture: data plus empty flag exceeds bus width");
   end

   logic [NCH*DW-1:0] heads;
   logic [NCH-1:0]    empty_v, full_v, pop_v;
   logic [BUS_W-1:0]  rd_next;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      spy_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (soft_clr),
         .wr_en   (run_active),
         .wr_data (sample_in[c*DW +: DW]),
         .rd_en   (pop_v[c]),
         .head    (heads[c*DW +: DW]),
         .empty   (empty_v[c]),
         .full    (full_v[c])
      );
   end

   spy_rd_mux #(
      .NCH(NCH), .DW(DW), .AW(AW), .BUS_W(BUS_W),
      .CH_BASE(CH_BASE), .STAT(STAT)
   ) u_mux (
      .rd_strobe (rd_strobe),
      .rd_addr   (rd_addr),
      .heads     (heads),
      .empty_v   (empty_v),
      .full_v    (full_v),
      .pop_v     (pop_v),
      .rd_next   (rd_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rd_data <= '0;
      else if (rd_strobe) rd_data <= rd_next;
   end
endmodule

// File: rtl/spy_capture_chk.sv
module spy_capture_chk #(
   parameter int unsigned NCH     = 8,
   parameter int unsigned DW      = 10,
   parameter int unsigned AW      = 8,
   parameter int unsigned BUS_W   = 16,
   parameter logic [7:0]  CH_BASE = 8'h35,
   parameter logic [7:0]  STAT    = 8'h71
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_active,
   input logic             soft_clr,
   input logic             rd_strobe,
   input logic [AW-1:0]    rd_addr,
   input logic [BUS_W-1:0] rd_data,
   input logic [NCH-1:0]   empty_v,
   input logic [NCH-1:0]   full_v
);
   logic ch_hit, sel_empty, mapped;

   always_comb begin
      ch_hit    = 1'b0;
      sel_empty = 1'b0;
      for (int c = 0; c < NCH; c++) begin
         if (rd_addr == AW'(CH_BASE + c)) begin
            ch_hit    = 1'b1;
            sel_empty = empty_v[c];
         end
      end
      mapped = ch_hit || (rd_addr == AW'(STAT));
   end

   assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> (empty_v == '1) && (full_v == '0));

   assert_idle_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_active && !rd_strobe && !soft_clr) |=> $stable(empty_v) && $stable(full_v));

   assert_full_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_strobe && !soft_clr) |=> (($past(full_v) & ~full_v) == '0));

   assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && ch_hit) |=> (rd_data[BUS_W-1:DW+1] == '0));

   assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && ch_hit && sel_empty) |=> (rd_data == BUS_W'(1 << DW)));

   assert_status_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && rd_addr == AW'(STAT)) |=>
         (rd_data[2*NCH-1:0] == $past({full_v, empty_v})));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_strobe |=> $stable(rd_data));

   assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !mapped) |=> (rd_data == '0));
endmodule

bind tp_spy_capture spy_capture_chk #(
   .NCH(NCH), .DW(DW), .AW(AW), .BUS_W(BUS_W), .CH_BASE(CH_BASE), .STAT(STAT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .run_active (run_active),
   .soft_clr   (soft_clr),
   .rd_strobe  (rd_strobe),
   .rd_addr    (rd_addr),
   .rd_data    (rd_data),
   .empty_v    (empty_v),
   .full_v     (full_v)
);

// File: tb/sim_tp_spy_capture.sv
module sim_tp_spy_capture;
   localparam int NCH = 8;
   localparam int DW  = 10;
   localparam int NV  = 6;
   localparam logic [9:0] PAT [NV] = '{10'h000, 10'h3FF, 10'h155, 10'h2AA, 10'h001, 10'h200};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              run_active = 1'b0;
   logic              soft_clr = 1'b0;
   logic [NCH*DW-1:0] sample_in = '0;
   logic              rd_strobe = 1'b0;
   logic [7:0]        rd_addr = '0;
   logic [15:0]       rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tp_spy_capture u0 (
      .clk(clk), .rst_n(rst_n), .run_active(run_active), .soft_clr(soft_clr),
      .sample_in(sample_in), .rd_strobe(rd_strobe), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   function automatic logic [9:0] lane_val(int k, int c);
      return PAT[k] ^ 10'(c * 73);
   endfunction

   task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic bus_read(logic [7:0] a, output logic [15:0] d);
      @(negedge clk);
      rd_strobe = 1'b1;
      rd_addr   = a;
      @(negedge clk);
      rd_strobe = 1'b0;
      d = rd_data;
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      check("R10 rd_data after reset", rd_data, 16'h0000);
      bus_read(8'h71, d);
      check("R10 status after reset", d, 16'h00FF);

      // R2: capture disabled
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         for (int c = 0; c < NCH; c++) sample_in[c*DW +: DW] = 10'(i * 17 + c);
      end
      bus_read(8'h71, d);
      check("R2 status with run low", d, 16'h00FF);
      bus_read(8'h35, d);
      check("R2/R5 empty ch1 read", d, 16'h0400);

      // R1/R4/R6: vector table pushed into all channels
      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         run_active = 1'b1;
         for (int c = 0; c < NCH; c++) sample_in[c*DW +: DW] = lane_val(k, c);
      end
      @(negedge clk);
      run_active = 1'b0;
      bus_read(8'h71, d);
      check("R7 status partial", d, 16'h0000);
      for (int c = 0; c < NCH; c++) begin
         for (int k = 0; k < NV; k++) begin
            bus_read(8'(8'h35 + c), d);
            check($sformatf("R1/R4/R6 ch%0d entry %0d", c + 1, k), d, {6'b0, lane_val(k, c)});
         end
         bus_read(8'(8'h35 + c), d);
         check($sformatf("R5 ch%0d drained", c + 1), d, 16'h0400);
      end

      // R3: overflow, first 16 kept
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         run_active = 1'b1;
         for (int c = 0; c < NCH; c++) sample_in[c*DW +: DW] = 10'(i + c * 64);
      end
      @(negedge clk);
      run_active = 1'b0;
      bus_read(8'h71, d);
      check("R3/R7 all full", d, 16'hFF00);
      for (int i = 0; i < 16; i++) begin
         bus_read(8'h37, d);
         check($sformatf("R3/R6 ch3 entry %0d", i), d, 16'(i + 128));
      end
      bus_read(8'h37, d);
      check("R3 surplus dropped", d, 16'h0400);
      bus_read(8'h71, d);
      check("R7 ch3 bit placement", d, 16'hFB04);

      // R9: hold and unmapped
      repeat (4) @(negedge clk);
      check("R9 hold without strobe", rd_data, 16'hFB04);
      bus_read(8'h34, d);
      check("R9 unmapped 0x34", d, 16'h0000);
      bus_read(8'h3D, d);
      check("R9 unmapped 0x3D", d, 16'h0000);

      // R8: clear wins over simultaneous capture
      @(negedge clk);
      soft_clr   = 1'b1;
      run_active = 1'b1;
      @(negedge clk);
      soft_clr   = 1'b0;
      run_active = 1'b0;
      bus_read(8'h71, d);
      check("R8 status after clear", d, 16'h00FF);
      bus_read(8'h3C, d);
      check("R8 ch8 empty after clear", d, 16'h0400);

      done = 1'b1;
      summary();
   end
endmodule